// File: doc/BRIEF.md
# I2C Master Bus Command Engine

This block is the bit-level engine of an I2C master. Software drives it through a small register file. A control word carries an enable, a two-bit command field and an acknowledge bit. Writing that word produces a single bus condition: a START, a repeated START or a STOP. Writing a byte to the data register shifts that byte out on the bus and then samples the slave's acknowledge. The engine drives the open-drain enables for SCL and SDA, waits while a slave holds SCL low, and raises a done flag when the operation finishes. A busy flag stays high while an operation is running.

Each bus condition and each byte is a separate register operation. Between two operations software must write the no-action command. The acknowledge bit has two roles. When the condition command is written, it chooses between a plain START and a repeated START. After a byte has been written, it holds the acknowledge received from the slave. Bus timing is set by a fixed prescaler and a writable divider. A pad-control bit can release both bus lines.

Top module: `i2c_bus_cmd_engine`

## Requirements
- R1: The control word sits at address 0. Its fields are enable at bit 0, command at bits 2:1 and acknowledge at bit 3. It reads back as {4'b0, ack, cmd, en} and resets to 0.
- R2: Command value 1 with bit 3 = 0 produces a START in three half-period steps, with (SCL,SDA) levels high/high, high/low, low/low.
- R3: Command value 1 with bit 3 = 1 produces a repeated START in four steps: low/high, high/high, high/low, low/low.
- R4: Command value 2 produces a STOP in three steps: low/low, high/low, high/high. After it both lines are released.
- R5: A write to the data register (address 1) sends the byte MSB first in 19 steps. Each bit takes a low step and then a high step with SDA held. Three steps follow: low/released, high/released and low/released. SDA changes only while SCL is low.
- R6: At the end of the acknowledge high step, the SDA input is latched into control bit 3 (1 = NAK, 0 = ACK).
- R7: Status bit 0 (address 2) is the done flag. It is set on the clock edge that ends an operation and is cleared by writing 1 to it.
- R8: Status bit 1 is busy. It is high from the accepting edge until the operation ends. While busy, writes to the control, data and divider registers are ignored.
- R9: An operation is launched only when enable is 1 and the stored command field is 0. The command value 3, and any launch attempt made without an intervening no-action write, starts nothing.
- R10: Pad register bit 2 (address 3) resets to 1. While it is 1, both output enables are held low.
- R11: The divider register at address 4 resets to DIV_RESET. Each half-period step lasts PRESCALE*(divider+1) clock cycles.
- R12: During a step that releases SCL, step timing pauses while the SCL input reads low.
- Output enables are active high (1 pulls the line low). Line levels in these requirements are the levels the engine requests, so a released line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for reads and writes |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from regAddr |
| sclIn | input | 1 | Sensed SCL line level |
| sdaIn | input | 1 | Sensed SDA line level |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |

## Verification
A launching write is taken on one clock edge, and the first step's line levels appear on the enables right after that edge. Every step then holds for exactly PRESCALE*(divider+1) cycles. Busy falls and done rises on the edge that ends the last step, and the latched acknowledge becomes readable on that same edge. The reference model turns every accepted command into a per-cycle queue of expected levels. It pops one entry per clock and compares the enables, and the status word while that address is selected, one time unit after each rising edge. Register read-backs are checked in the low half of the clock, so that no edge falls inside a read.

// File: rtl/i2ceng_pkg.sv
package i2ceng_pkg;
  typedef enum logic [2:0] {
    OP_IDLE, OP_START, OP_RESTART, OP_STOP, OP_BYTE
  } busOp_t;

  // strobes from the sequencer to the register/datapath side
  typedef struct packed {
    logic shiftNext;
    logic captureAck;
    logic opDone;
  } engStrobe_t;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_DATA = 3'd1;
  localparam logic [2:0] ADDR_STAT = 3'd2;
  localparam logic [2:0] ADDR_PAD  = 3'd3;
  localparam logic [2:0] ADDR_DIV  = 3'd4;
endpackage

// File: rtl/i2ceng_seq.sv
module i2ceng_seq
  import i2ceng_pkg::*;
#(
  parameter int PRESCALE = 2,
  parameter int DIV_W    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  busOp_t           reqOp,
  input  logic             shiftMsb,
  input  logic [DIV_W-1:0] divTicks,
  input  logic             sclIn,
  output logic             busy,
  output logic             sclLvl,
  output logic             sdaLvl,
  output engStrobe_t       strobe
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int STEP_W = 5;
  localparam logic [STEP_W-1:0] BIT_STEPS = STEP_W'(16);

  busOp_t            opQ;
  logic [STEP_W-1:0] stepQ, lastStep;
  logic [PW-1:0]     preQ;
  logic [DIV_W-1:0]  tickQ;
  logic [1:0]        lineQ, stepLvl;
  logic              tick, stretchWait, stepEnd;

  assign busy = (opQ != OP_IDLE);

  always_comb begin
    unique case (opQ)
      OP_RESTART: lastStep = STEP_W'(3);
      OP_BYTE:    lastStep = STEP_W'(18);
      default:    lastStep = STEP_W'(2);
    endcase
  end

  // requested {scl, sda} level for the current step
  always_comb begin
    stepLvl = lineQ;
    unique case (opQ)
      OP_START:   stepLvl = (stepQ == 0) ? 2'b11 : (stepQ == 1) ? 2'b10 : 2'b00;
      OP_RESTART: stepLvl = (stepQ == 0) ? 2'b01 : (stepQ == 1) ? 2'b11 :
                            (stepQ == 2) ? 2'b10 : 2'b00;
      OP_STOP:    stepLvl = (stepQ == 0) ? 2'b00 : (stepQ == 1) ? 2'b10 : 2'b11;
      OP_BYTE: begin
        if (stepQ < BIT_STEPS)       stepLvl = {stepQ[0], shiftMsb};
        else if (stepQ == 5'd17)     stepLvl = 2'b11;
        else                         stepLvl = 2'b01;
      end
      default: stepLvl = lineQ;
    endcase
  end

  assign sclLvl      = stepLvl[1];
  assign sdaLvl      = stepLvl[0];
  assign tick        = (preQ == PW'(PRESCALE - 1));
  assign stretchWait = sclLvl && !sclIn;
  assign stepEnd     = busy && tick && !stretchWait && (tickQ == divTicks);

  assign strobe.shiftNext  = stepEnd && (opQ == OP_BYTE) && (stepQ < BIT_STEPS) && stepQ[0];
  assign strobe.captureAck = stepEnd && (opQ == OP_BYTE) && (stepQ == 5'd17);
  assign strobe.opDone     = stepEnd && (stepQ == lastStep);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ   <= OP_IDLE;
      stepQ <= '0;
      preQ  <= '0;
      tickQ <= '0;
      lineQ <= 2'b11;
    end else if (!busy) begin
      if (reqValid) begin
        opQ   <= reqOp;
        stepQ <= '0;
        preQ  <= '0;
        tickQ <= '0;
      end
    end else begin
      preQ <= tick ? '0 : preQ + 1'b1;
      if (tick && !stretchWait) begin
        if (tickQ == divTicks) begin
          tickQ <= '0;
          if (stepQ == lastStep) begin
            opQ   <= OP_IDLE;
            lineQ <= stepLvl;
          end else begin
            stepQ <= stepQ + 1'b1;
          end
        end else begin
          tickQ <= tickQ + 1'b1;
        end
      end
    end
  end

  assert_launch_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.opDone |=> !busy);
  assert_sda_steady_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opQ == OP_BYTE && $past(opQ) == OP_BYTE && sclLvl && $past(sclLvl)) |-> $stable(sdaLvl));
  assert_stretch_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sclLvl && !sclIn) |=> $stable(stepQ));
endmodule

// File: rtl/i2ceng_regs.sv
module i2ceng_regs
  import i2ceng_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic             busy,
  input  engStrobe_t       strobe,
  input  logic             sdaIn,
  output logic             reqValid,
  output busOp_t           reqOp,
  output logic             shiftMsb,
  output logic [DIV_W-1:0] divTicks,
  output logic             padOff
);
  logic       enQ, ackQ, doneQ, padQ;
  logic [1:0] cmdQ;
  logic [7:0] shiftQ;
  logic [DIV_W-1:0] divQ;
  logic ctrlWr, dataWr, armed, byteGo;

  assign ctrlWr = wrEn && (addr == ADDR_CTRL) && !busy;
  assign dataWr = wrEn && (addr == ADDR_DATA) && !busy;
  assign armed  = (cmdQ == 2'd0);
  assign byteGo = dataWr && enQ && armed;

  always_comb begin
    reqValid = 1'b0;
    reqOp    = OP_IDLE;
    if (ctrlWr && wrData[0] && armed) begin
      if (wrData[2:1] == 2'd1) begin
        reqValid = 1'b1;
        reqOp    = wrData[3] ? OP_RESTART : OP_START;
      end else if (wrData[2:1] == 2'd2) begin
        reqValid = 1'b1;
        reqOp    = OP_STOP;
      end
    end else if (byteGo) begin
      reqValid = 1'b1;
      reqOp    = OP_BYTE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      cmdQ   <= 2'd0;
      ackQ   <= 1'b0;
      doneQ  <= 1'b0;
      padQ   <= 1'b1;
      divQ   <= DIV_W'(DIV_RESET);
      shiftQ <= '0;
    end else begin
      if (ctrlWr) begin
        enQ  <= wrData[0];
        cmdQ <= wrData[2:1];
        ackQ <= wrData[3];
      end else if (strobe.captureAck) begin
        ackQ <= sdaIn;
      end
      if (strobe.opDone)
        doneQ <= 1'b1;
      else if (wrEn && addr == ADDR_STAT && wrData[0])
        doneQ <= 1'b0;
      if (wrEn && addr == ADDR_PAD)
        padQ <= wrData[2];
      if (wrEn && addr == ADDR_DIV && !busy)
        divQ <= DIV_W'(wrData);
      if (byteGo)
        shiftQ <= wrData;
      else if (strobe.shiftNext)
        shiftQ <= {shiftQ[6:0], 1'b0};
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_CTRL: rdData = {4'b0, ackQ, cmdQ, enQ};
      ADDR_STAT: rdData = {6'b0, busy, doneQ};
      ADDR_PAD:  rdData = {5'b0, padQ, 2'b0};
      ADDR_DIV:  rdData = 8'(divQ);
      default:   rdData = 8'h00;
    endcase
  end

  assign shiftMsb = shiftQ[7];
  assign divTicks = divQ;
  assign padOff   = padQ;

  assert_done_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.opDone |=> doneQ);
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_CTRL && busy) |=> ($stable(enQ) && $stable(cmdQ)));
  assert_no_rearm_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && wrEn && addr == ADDR_DATA) |-> !reqValid);
endmodule

// File: rtl/i2c_bus_cmd_engine.sv
module i2c_bus_cmd_engine
  import i2ceng_pkg::*;
#(
  parameter int PRESCALE  = 2,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sclOe,
  output logic       sdaOe
);
  engStrobe_t       strobe;
  busOp_t           reqOp;
  logic             reqValid, busy, shiftMsb, padOff, sclLvl, sdaLvl;
  logic [DIV_W-1:0] divTicks;

  i2ceng_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .rdData(regRdData), .busy(busy), .strobe(strobe), .sdaIn(sdaIn),
    .reqValid(reqValid), .reqOp(reqOp), .shiftMsb(shiftMsb),
    .divTicks(divTicks), .padOff(padOff)
  );

  i2ceng_seq #(.PRESCALE(PRESCALE), .DIV_W(DIV_W)) uSeq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .shiftMsb(shiftMsb), .divTicks(divTicks), .sclIn(sclIn),
    .busy(busy), .sclLvl(sclLvl), .sdaLvl(sdaLvl), .strobe(strobe)
  );

  assign sclOe = !padOff && !sclLvl;
  assign sdaOe = !padOff && !sdaLvl;
endmodule

// File: tb/i2c_bus_cmd_engine_test.sv
module i2c_bus_cmd_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 2;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [2:0] addr = 3'd2;
  logic [7:0] wd = 8'h00, rd;
  logic sclOe, sdaOe, sclIn, sdaIn;
  logic stretch = 1'b0, slaveNak = 1'b1;

  assign sclIn = ~sclOe & ~stretch;
  assign sdaIn = ~sdaOe & slaveNak;

  i2c_bus_cmd_engine #(.PRESCALE(PRE), .DIV_W(8), .DIV_RESET(1)) uut (
    .clk(clk), .rstN(rstN), .regWrEn(wrEn), .regAddr(addr), .regWrData(wd),
    .regRdData(rd), .sclIn(sclIn), .sdaIn(sdaIn), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vecs = 0, bad = 0;
  logic [1:0] q[$];
  logic [1:0] pendSeq[$];
  logic [1:0] lvl, lastLvl;
  logic [1:0] mCmd = 2'd0, mLine = 2'b11;
  bit pendLaunch = 0, pendByte = 0, curByte = 0, busyExp = 0, modelOn = 0;
  bit mEn = 0, mAck = 0, mDone = 0, mPad = 1;
  int mDiv = 1;
  string tag = "R1";

  task automatic check(string what, logic [7:0] act, logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle reference model
  always @(posedge clk) begin
    #1;
    if (modelOn) begin
      if (pendLaunch) begin
        q = pendSeq;
        pendLaunch = 0;
        curByte = pendByte;
      end else if (q.size() > 0) begin
        lastLvl = q.pop_front();
        if (q.size() == 0) begin
          mLine = lastLvl;
          mDone = 1;
          if (curByte) mAck = slaveNak;
        end
      end
      busyExp = (q.size() > 0);
      lvl = busyExp ? q[0] : mLine;
      check("bus enables", {6'b0, sclOe, sdaOe}, mPad ? 8'h00 : {6'b0, ~lvl});
      if (addr == 3'd2) check("status", rd, {6'b0, busyExp, mDone});
    end
  end

  // kind: 0 start, 1 repeated start, 2 stop, 3 byte
  task automatic launch(int kind, logic [7:0] d);
    logic [1:0] steps[$];
    int len;
    steps = {};
    case (kind)
      0: begin steps.push_back(2'b11); steps.push_back(2'b10); steps.push_back(2'b00); end
      1: begin steps.push_back(2'b01); steps.push_back(2'b11);
               steps.push_back(2'b10); steps.push_back(2'b00); end
      2: begin steps.push_back(2'b00); steps.push_back(2'b10); steps.push_back(2'b11); end
      default: begin
        for (int i = 7; i >= 0; i--) begin
          steps.push_back({1'b0, d[i]});
          steps.push_back({1'b1, d[i]});
        end
        steps.push_back(2'b01); steps.push_back(2'b11); steps.push_back(2'b01);
      end
    endcase
    len = PRE * (mDiv + 1);
    pendSeq = {};
    foreach (steps[k])
      for (int j = 0; j < len; j++) pendSeq.push_back(steps[k]);
    pendLaunch = 1;
    pendByte = (kind == 3);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    case (a)
      3'd0: if (!busyExp) begin
        if (d[0] && mCmd == 2'd0 && (d[2:1] == 2'd1 || d[2:1] == 2'd2))
          launch(d[2:1] == 2'd2 ? 2 : (d[3] ? 1 : 0), 8'h00);
        mEn = d[0]; mCmd = d[2:1]; mAck = d[3];
      end
      3'd1: if (!busyExp && mEn && mCmd == 2'd0) launch(3, d);
      3'd2: if (d[0]) mDone = 0;
      3'd3: mPad = d[2];
      3'd4: if (!busyExp) mDiv = d;
      default: ;
    endcase
    addr = a; wd = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; addr = 3'd2;
  endtask

  task automatic rdchk(logic [2:0] a, logic [7:0] exp, string t);
    @(negedge clk);
    addr = a;
    #1;
    tag = t;
    check("readback", rd, exp);
    addr = 3'd2;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (pendLaunch || busyExp) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelOn = 1;
    // reset values
    rdchk(3'd0, 8'h00, "R1");
    rdchk(3'd3, 8'h04, "R10");
    rdchk(3'd4, 8'h01, "R11");
    tag = "R10"; wr(3'd3, 8'h00);
    // disabled engine launches nothing
    tag = "R9"; wr(3'd0, 8'h02);
    repeat (10) @(negedge clk);
    rdchk(3'd2, 8'h00, "R9");
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h01);
    rdchk(3'd0, 8'h01, "R1");
    // start condition
    tag = "R2"; wr(3'd0, 8'h03); waitIdle();
    rdchk(3'd2, 8'h01, "R7");
    tag = "R7"; wr(3'd2, 8'h01);
    rdchk(3'd2, 8'h00, "R7");
    // byte with ACK, plus writes while busy
    wr(3'd0, 8'h01);
    slaveNak = 1'b0;
    tag = "R5"; wr(3'd1, 8'hA5);
    tag = "R8"; wr(3'd0, 8'h05); wr(3'd1, 8'hFF); wr(3'd4, 8'h03);
    rdchk(3'd4, 8'h01, "R8");
    rdchk(3'd0, 8'h01, "R8");
    tag = "R5"; waitIdle();
    rdchk(3'd0, 8'h01, "R6");
    wr(3'd2, 8'h01);
    // byte with NAK
    slaveNak = 1'b1;
    tag = "R5"; wr(3'd1, 8'h3C); waitIdle();
    rdchk(3'd0, 8'h09, "R6");
    wr(3'd2, 8'h01);
    // repeated start
    tag = "R3"; wr(3'd0, 8'h0B); waitIdle();
    wr(3'd2, 8'h01);
    // no re-arm: both attempts ignored
    tag = "R9"; wr(3'd1, 8'h55); wr(3'd0, 8'h0B);
    repeat (6) @(negedge clk);
    rdchk(3'd2, 8'h00, "R9");
    // divider changes
    wr(3'd0, 8'h01);
    tag = "R11"; wr(3'd4, 8'h00);
    rdchk(3'd4, 8'h00, "R11");
    tag = "R4"; wr(3'd0, 8'h05); waitIdle();
    wr(3'd2, 8'h01);
    tag = "R11"; wr(3'd4, 8'h02);
    wr(3'd0, 8'h01); wr(3'd0, 8'h03); waitIdle();
    wr(3'd2, 8'h01);
    wr(3'd0, 8'h01);
    tag = "R4"; wr(3'd0, 8'h05); waitIdle();
    wr(3'd2, 8'h01);
    // pads disabled during an operation
    tag = "R10"; wr(3'd3, 8'h04);
    wr(3'd0, 8'h01); wr(3'd0, 8'h03); waitIdle();
    rdchk(3'd3, 8'h04, "R10");
    tag = "R10"; wr(3'd3, 8'h00);
    wr(3'd2, 8'h01);
    wr(3'd0, 8'h01); wr(3'd0, 8'h05); waitIdle();
    wr(3'd2, 8'h01);
    // SCL held low by a slave
    wr(3'd0, 8'h01);
    modelOn = 0;
    stretch = 1'b1;
    tag = "R12"; wr(3'd0, 8'h05);
    repeat (PRE * (mDiv + 1) * 3 + 10) @(negedge clk);
    rdchk(3'd2, 8'h02, "R12");
    stretch = 1'b0;
    repeat (PRE * (mDiv + 1) * 3) @(negedge clk);
    rdchk(3'd2, 8'h01, "R12");
    pendLaunch = 0; q = {}; busyExp = 0; mLine = 2'b11; mDone = 1;
    modelOn = 1;
    tag = "R7"; wr(3'd2, 8'h01);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule